// File: doc/BRIEF.md
# Multi-Slot SD Host Wrapper Register Block

This block sits in front of up to two SD host slot controllers and decodes a 4 KiB register window on a simple 32-bit register port. The first 256 bytes hold a small file of global registers with fixed reset values. Each present slot owns a later 256-byte page of the window. Accesses to that page are forwarded to the slot's stub register port.

Each slot's capability word and maximum-current word live in the wrapper. Software reaches them through alias offsets in the global page, and the wrapper drives them out to the slots. Each slot's interrupt line is mirrored into a status register. One combined interrupt output follows the most recent edge seen on any slot line.

Every read answers one cycle after its request. An access that is not a full aligned word, or that falls outside the decoded window, is dropped and reported with a one-cycle error pulse.

Top module: `sdhost_wrap_regs`

## Requirements
- R1: After reset, offset 0x00 reads 0x00030000 and offset 0x04 reads 0x00000005. Every other global word reads 0, each present slot's capability word equals CAP_INIT, each maximum-current word is 0, and `irq` is 0.
- R2: A read request in cycle t gives `rd_valid`=1 with its data on `rd_data` in cycle t+1. A write request never raises `rd_valid`.
- R3: Global offsets 0x00 to 0xF8 that are not aliases are plain 32-bit read/write storage. Word index = offset/4. This includes 0x08, 0xEC and 0xF0, which have no side effects.
- R4: Offsets 0x10 and 0x18 hold slot 0's capability and maximum-current words. Offsets 0x20 and 0x28 hold the same words for slot 1. These words are driven on `slot_cap` and `slot_maxcur`, with slot n in bits [32n+31:32n]. For an absent slot, these offsets are plain storage.
- R5: The status word at 0xFC has bit n equal to slot n's interrupt line, sampled one cycle earlier. Bits for absent slots and bits 31:2 read 0. Writes to 0xFC are ignored.
- R6: A rising edge on any present slot line sets `irq` one cycle later. A falling edge clears it one cycle later, even if another line stays high. When a rise and a fall occur together, the rise wins. With no edge, `irq` holds.
- R7: Slot i's page begins at byte (i+1)*0x100. A valid access there pulses `slot_req[i]` in the request cycle, with `slot_addr` set to the page offset and `slot_we`/`slot_wdata` carrying the request. A read returns that slot's `slotN_rdata`.
- R8: An address at or above (NUM_SLOTS+1)*0x100 reads 0, writes nothing, and pulses `acc_err` one cycle after the request.
- R9: Only full word accesses are accepted (`req_be`=4'hF and `req_addr[1:0]`=0). Any other access reads 0, changes nothing, raises no `slot_req`, and pulses `acc_err` one cycle later.
- R10: `slot_spec_ver` reports SD specification version 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the 4 KiB window |
| req_be | input | 4 | Byte enables; only 4'hF is valid |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Error pulse for a rejected access |
| slot_req | output | 2 | Per-slot access strobe |
| slot_we | output | 1 | Write flag forwarded to slots |
| slot_addr | output | 8 | Offset within the slot page |
| slot_wdata | output | 32 | Write data forwarded to slots |
| slot0_rdata | input | 32 | Slot 0 stub read data for `slot_addr` |
| slot1_rdata | input | 32 | Slot 1 stub read data for `slot_addr` |
| slot_cap | output | 64 | Capability words, slot n in bits [32n+31:32n] |
| slot_maxcur | output | 64 | Maximum-current words, slot n in bits [32n+31:32n] |
| slot_spec_ver | output | 4 | SD specification version reported to slots |
| slot_irq | input | 2 | Slot interrupt lines |
| irq | output | 1 | Combined interrupt |

## Verification
The in-line assertions check, on every cycle, the parts of the behaviour that need no memory of earlier writes. These are:
- the one-cycle read response;
- the error pulse for rejected and out-of-range accesses, and the zero data those reads return;
- the one-hot slot strobe;
- the one-cycle response of `irq` to rising and falling slot lines.

What only the bench's scenarios can show depends on stored state: that a word written at one offset reads back there and nowhere else, that the alias offsets reach the slot outputs, that ignored writes leave the stored word untouched, and the exact reset values.

// File: rtl/sdhost_wrap_regs.sv
module sdhost_wrap_regs #(
  parameter int          NUM_SLOTS = 2,
  parameter logic [31:0] INFO_RST  = 32'h0003_0000,
  parameter logic [31:0] DBNC_RST  = 32'h0000_0005,
  parameter logic [31:0] CAP_INIT  = 32'h01E8_0080,
  parameter int          SPEC_VER  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        acc_err,
  output logic [1:0]  slot_req,
  output logic        slot_we,
  output logic [7:0]  slot_addr,
  output logic [31:0] slot_wdata,
  input  logic [31:0] slot0_rdata,
  input  logic [31:0] slot1_rdata,
  output logic [63:0] slot_cap,
  output logic [63:0] slot_maxcur,
  output logic [3:0]  slot_spec_ver,
  input  logic [1:0]  slot_irq,
  output logic        irq
);
  localparam int          NWORDS  = 64;
  localparam logic [1:0]  PRESENT = (NUM_SLOTS >= 2) ? 2'b11 : (NUM_SLOTS == 1) ? 2'b01 : 2'b00;

  logic [31:0] gregs [NWORDS];
  logic [31:0] cap_q [2];
  logic [31:0] mc_q  [2];
  logic [1:0]  lvl_q;
  logic [31:0] rd_next;

  wire       full    = (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
  wire [3:0] page    = req_addr[11:8];
  wire [5:0] widx    = req_addr[7:2];
  wire       in_glob = (page == 4'd0);
  wire [1:0] in_slot = {(page == 4'd2) && PRESENT[1], (page == 4'd1) && PRESENT[0]};
  wire       ok      = full && (in_glob || (|in_slot));
  wire       is_stat = in_glob && (widx == 6'h3F);
  wire       hit_c0  = in_glob && (widx == 6'h04) && PRESENT[0];
  wire       hit_m0  = in_glob && (widx == 6'h06) && PRESENT[0];
  wire       hit_c1  = in_glob && (widx == 6'h08) && PRESENT[1];
  wire       hit_m1  = in_glob && (widx == 6'h0A) && PRESENT[1];
  wire       do_wr   = req_valid && req_write && ok;
  wire       do_rd   = req_valid && !req_write;
  wire [1:0] live    = slot_irq & PRESENT;
  wire       rise    = |(live & ~lvl_q);
  wire       fall    = |(~live & lvl_q);

  assign slot_req      = (req_valid && full) ? in_slot : 2'b00;
  assign slot_we       = req_write;
  assign slot_addr     = req_addr[7:0];
  assign slot_wdata    = req_wdata;
  assign slot_cap      = {cap_q[1], cap_q[0]};
  assign slot_maxcur   = {mc_q[1], mc_q[0]};
  assign slot_spec_ver = 4'(SPEC_VER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++)
        gregs[i] <= (i == 0) ? INFO_RST : (i == 1) ? DBNC_RST : 32'h0;
    end else if (do_wr && in_glob && !is_stat) begin
      gregs[widx] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q[0] <= CAP_INIT; cap_q[1] <= PRESENT[1] ? CAP_INIT : 32'h0;
      mc_q[0]  <= 32'h0;    mc_q[1]  <= 32'h0;
      if (!PRESENT[0]) cap_q[0] <= 32'h0;
    end else if (do_wr) begin
      if (hit_c0) cap_q[0] <= req_wdata;
      if (hit_m0) mc_q[0]  <= req_wdata;
      if (hit_c1) cap_q[1] <= req_wdata;
      if (hit_m1) mc_q[1]  <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 2'b00;
      irq   <= 1'b0;
    end else begin
      lvl_q <= live;
      if (rise)      irq <= 1'b1;
      else if (fall) irq <= 1'b0;
    end
  end

  always_comb begin
    rd_next = 32'h0;
    if (ok) begin
      if (in_slot[0])   rd_next = slot0_rdata;
      else if (in_slot[1]) rd_next = slot1_rdata;
      else if (hit_c0)  rd_next = cap_q[0];
      else if (hit_m0)  rd_next = mc_q[0];
      else if (hit_c1)  rd_next = cap_q[1];
      else if (hit_m1)  rd_next = mc_q[1];
      else if (is_stat) rd_next = {30'h0, lvl_q};
      else              rd_next = gregs[widx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      rd_data  <= do_rd ? rd_next : 32'h0;
      acc_err  <= req_valid && !ok;
    end
  end

  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  assert_no_wr_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rd_valid);
  assert_out_of_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr >= 12'((NUM_SLOTS + 1) * 256))) |=> acc_err);
  assert_err_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && rd_valid) |-> (rd_data == 32'h0));
  assert_partial_rejected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_be != 4'hF)) |-> (slot_req == 2'b00));
  assert_partial_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_be != 4'hF)) |=> acc_err);
  assert_slot_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_req));
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(slot_irq & PRESENT & ~lvl_q)) |=> irq);
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(slot_irq & PRESENT & ~lvl_q)) && (|(~slot_irq & PRESENT & lvl_q))) |=> !irq);
endmodule

// File: tb/test_sdhost_wrap_regs.sv
`timescale 1ns/1ps
module test_sdhost_wrap_regs;
  localparam logic [31:0] CAPV = 32'h01E8_0080;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [3:0]  req_be = 0;
  logic [31:0] req_wdata = 0;
  logic rd_valid, acc_err, slot_we, irq;
  logic [31:0] rd_data, slot_wdata, slot0_rdata, slot1_rdata;
  logic [1:0]  slot_req;
  logic [1:0]  slot_irq = 0;
  logic [7:0]  slot_addr;
  logic [63:0] slot_cap, slot_maxcur;
  logic [3:0]  slot_spec_ver;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] mem [64];
  logic [31:0] mcap [2];
  logic [31:0] mmc [2];
  logic [1:0]  mlvl = 0;

  always #2 clk = ~clk;

  assign slot0_rdata = {16'hA000, 8'h00, slot_addr};
  assign slot1_rdata = {16'hB001, 8'h00, slot_addr};

  sdhost_wrap_regs #(.NUM_SLOTS(2), .CAP_INIT(CAPV)) i_sdhost_wrap_regs (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic bad(input logic [11:0] a, input logic [3:0] be);
    return (be != 4'hF) || (a[1:0] != 0) || (a[11:8] > 4'd2);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a, input logic [3:0] be);
    if (bad(a, be)) return 32'h0;
    if (a[11:8] == 4'd1) return {16'hA000, 8'h00, a[7:0]};
    if (a[11:8] == 4'd2) return {16'hB001, 8'h00, a[7:0]};
    case (a[7:0])
      8'h10: return mcap[0];
      8'h18: return mmc[0];
      8'h20: return mcap[1];
      8'h28: return mmc[1];
      8'hFC: return {30'h0, mlvl};
      default: return mem[a[7:2]];
    endcase
  endfunction

  task automatic model_wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    if (bad(a, be) || a[11:8] != 0) return;
    case (a[7:0])
      8'h10: mcap[0] = d;
      8'h18: mmc[0] = d;
      8'h20: mcap[1] = d;
      8'h28: mmc[1] = d;
      8'hFC: ;
      default: mem[a[7:2]] = d;
    endcase
  endtask

  task automatic acc(input logic we, input logic [11:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er,
                     output logic [1:0] sreq, output logic rv);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_be = be; req_wdata = wd;
    #1 sreq = slot_req;
    @(negedge clk);
    req_valid = 0;
    rd = rd_data; er = acc_err; rv = rd_valid;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [3:0] be);
    logic [31:0] d; logic e, v; logic [1:0] s;
    acc(0, a, be, 0, d, e, s, v);
    check({tag, " data"}, d, exp_rd(a, be));
    check({tag, " err"}, 32'(e), 32'(bad(a, be)));
    check({tag, " rd_valid R2"}, 32'(v), 1);
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] r; logic e, v; logic [1:0] s;
    acc(1, a, be, d, r, e, s, v);
    model_wr(a, be, d);
    check("write err R8/R9", 32'(e), 32'(bad(a, be)));
    check("write no rd_valid R2", 32'(v), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic e, v; logic [1:0] s;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem[i] = 0;
    mem[0] = 32'h0003_0000; mem[1] = 32'h5;
    mcap[0] = CAPV; mcap[1] = CAPV; mmc[0] = 0; mmc[1] = 0;

    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 cap out", slot_cap[31:0], CAPV);
    check("R1 maxcur out", slot_maxcur[63:32], 0);
    rd_chk("R1 info", 12'h000, 4'hF);
    check("R1 info value", exp_rd(12'h000, 4'hF), 32'h0003_0000);
    rd_chk("R1 debounce", 12'h004, 4'hF);
    rd_chk("R1 bus", 12'h008, 4'hF);
    rd_chk("R1 cap0", 12'h010, 4'hF);
    rd_chk("R1 stat", 12'h0FC, 4'hF);
    // R10
    check("R10 spec ver", 32'(slot_spec_ver), 2);

    // R3 plain storage
    wr(12'h0F0, 4'hF, 32'hDEAD_BEEF);
    wr(12'h0EC, 4'hF, 32'h1234_5678);
    wr(12'h008, 4'hF, 32'h0000_00AA);
    rd_chk("R3 0xF0", 12'h0F0, 4'hF);
    rd_chk("R3 0xEC", 12'h0EC, 4'hF);
    rd_chk("R3 0x08", 12'h008, 4'hF);

    // R4 aliases
    wr(12'h010, 4'hF, 32'hC0C0_0001);
    wr(12'h028, 4'hF, 32'h0000_0777);
    check("R4 slot0 cap out", slot_cap[31:0], 32'hC0C0_0001);
    check("R4 slot1 maxcur out", slot_maxcur[63:32], 32'h0000_0777);
    rd_chk("R4 alias 0x10", 12'h010, 4'hF);
    rd_chk("R4 alias 0x28", 12'h028, 4'hF);
    rd_chk("R4 plain 0x14", 12'h014, 4'hF);

    // R7 slot windows
    acc(0, 12'h104, 4'hF, 0, d, e, s, v);
    check("R7 slot0 req", 32'(s), 1);
    check("R7 slot0 data", d, 32'hA000_0004);
    acc(1, 12'h2F0, 4'hF, 32'h55, d, e, s, v);
    check("R7 slot1 req", 32'(s), 2);
    rd_chk("R7 slot1 read", 12'h2F0, 4'hF);

    // R8 out of range
    rd_chk("R8 read 0x300", 12'h300, 4'hF);
    acc(1, 12'hFFC, 4'hF, 32'h1, d, e, s, v);
    check("R8 write err", 32'(e), 1);
    check("R8 write no slot req", 32'(s), 0);
    rd_chk("R8 read 0xFFC", 12'hFFC, 4'hF);

    // R9 partial / misaligned
    acc(1, 12'h008, 4'h3, 32'hFFFF_FFFF, d, e, s, v);
    check("R9 partial err", 32'(e), 1);
    rd_chk("R9 0x08 unchanged", 12'h008, 4'hF);
    acc(0, 12'h106, 4'hF, 0, d, e, s, v);
    check("R9 misaligned no slot req", 32'(s), 0);
    check("R9 misaligned data", d, 0);
    check("R9 misaligned err", 32'(e), 1);

    // R5/R6 interrupts
    @(negedge clk); slot_irq = 2'b01; mlvl = 2'b01;
    @(negedge clk);
    check("R6 rise sets irq", 32'(irq), 1);
    rd_chk("R5 stat slot0", 12'h0FC, 4'hF);
    wr(12'h0FC, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R5 stat write ignored", 12'h0FC, 4'hF);
    @(negedge clk); slot_irq = 2'b11; mlvl = 2'b11;
    @(negedge clk);
    check("R6 second rise", 32'(irq), 1);
    slot_irq = 2'b10; mlvl = 2'b10;
    @(negedge clk);
    check("R6 fall clears irq", 32'(irq), 0);
    rd_chk("R5 stat slot1", 12'h0FC, 4'hF);
    slot_irq = 2'b01; mlvl = 2'b01;
    @(negedge clk);
    check("R6 simultaneous rise wins", 32'(irq), 1);
    slot_irq = 2'b00; mlvl = 2'b00;
    @(negedge clk);
    check("R6 last fall", 32'(irq), 0);
    @(negedge clk);
    check("R6 hold", 32'(irq), 0);

    // Random mix R2 R3 R4 R7 R8 R9
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [3:0]  be;
      logic [31:0] wd;
      a  = 12'($urandom_range(0, 12'h3FF)) & 12'hFFC;
      if ($urandom_range(0, 9) == 0) a[1:0] = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 3) == 0) a = {4'h0, a[7:0]};
      be = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      wd = $urandom;
      if ($urandom_range(0, 1) == 1) wr(a, be, wd);
      else rd_chk("R3 random read", a, be);
    end
    check("R4 final cap out", slot_cap, {mcap[1], mcap[0]});
    check("R4 final maxcur out", slot_maxcur[31:0], mmc[0]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule